// File: doc/BRIEF.md
# Float64 normalized mantissa extractor

This unit takes one IEEE-754 double-precision operand and returns another double. The result keeps the operand's significand and replaces its exponent, so that the magnitude of the result lies in one of four selectable intervals. A two-bit sign control chooses the sign of the result. It can also declare negative operands invalid, in which case the unit returns the default quiet NaN. Zeros, infinities and NaNs take fixed results. Subnormal operands are normalized before the exponent is replaced, unless the denormals-are-zero mode is on.

The datapath is combinational and finishes in one cycle: a leading-zero counter feeds a barrel shifter for the subnormal case. One register stage captures the result and the two flags. Operands may change on every clock, and each result appears one clock edge after its operand is presented.

Top module: `fp64_mant_norm`

## Requirements
- R1: Reset clears the result and both flags to zero. Each result and its flags appear at the outputs on the first rising clock edge after the operand, control and mode inputs are applied, and stay unchanged until the next rising edge.
- R2: Interval code `ctrl_i[1:0]=00` ([1,2)) gives a result biased exponent of 1023. Code `10` ([1/2,1)) gives 1022. In both cases the 52-bit fraction field is copied unchanged.
- R3: Interval code `01` ([1/2,2)) gives exponent 1022 when the unbiased operand exponent is odd, and 1023 when it is even.
- R4: Interval code `11` ([3/4,3/2)) gives exponent 1022 when fraction bit 51 is 1, and 1023 when it is 0.
- R5: On finite nonzero results, the sign is 0 when `ctrl_i[2]` is set and otherwise copies the operand sign.
- R6: A NaN operand (exponent 2047, fraction nonzero) returns the operand with fraction bit 51 forced to 1, keeping the sign and the other payload bits, and ignoring the interval. `invalid_o` is 1 exactly when fraction bit 51 of the operand was 0.
- R7: +0 and +infinity return +1.0 (0x3FF0000000000000). -0 returns +1.0 when `ctrl_i[2]` is set and -1.0 (0xBFF0000000000000) otherwise, even when `ctrl_i[3]` is set. No flag is raised.
- R8: A negative operand that is not zero and not a NaN, with `ctrl_i[3]` set, returns 0xFFF8000000000000 and raises `invalid_o`. This includes -infinity and negative subnormals.
- R9: -infinity with `ctrl_i[3]` clear returns +1.0 when `ctrl_i[2]` is set and -1.0 otherwise, with no flag.
- R10: With `daz_i` high, any operand whose exponent field is 0 is handled as a zero of the same sign, and `denorm_o` stays 0.
- R11: With `daz_i` low, a subnormal operand is normalized. Its fraction is shifted left by (leading zeros + 1), and its unbiased exponent is taken as minus that shift count. The interval rules of R2–R4 then apply to the shifted fraction and to that exponent.
- R12: `denorm_o` is 1 exactly when a subnormal operand reaches the normalization path (`daz_i` low, and not cut off by R8). It is never 1 together with `invalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 64 | Double-precision operand |
| ctrl_i | input | 4 | [1:0] interval code, [3:2] sign control |
| daz_i | input | 1 | Denormals-are-zero mode |
| res_o | output | 64 | Registered result |
| invalid_o | output | 1 | Registered invalid flag |
| denorm_o | output | 1 | Registered denormal flag |

## Verification
Two paths can both claim a negative subnormal operand: normalization, which would raise `denorm_o`, and the sign-control invalid rule, which would raise `invalid_o`. The bench applies such operands with `ctrl_i[3]` both set and clear, and with `daz_i` both on and off. It expects the invalid rule to win and suppress the denormal flag; with the mode bit on, it expects the zero rule to win over both. Random operands biased toward exponent 0 keep producing this collision, and a reference function in the bench judges each case. The checker also asserts on every cycle that the two flags are never high together.

// File: rtl/fp64_mant_pkg.sv
package fp64_mant_pkg;

    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int FP_W   = 1 + EXP_W + FRAC_W;
    localparam int SHW    = $clog2(FRAC_W + 1);

    localparam logic [EXP_W-1:0] EXP_ALL1 = '1;
    localparam logic [EXP_W-1:0] EXP_ONE  = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] EXP_HALF = EXP_ONE - 1'b1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef struct packed {
        fp_t  res;
        logic inv;
        logic den;
    } mant_out_t;

    typedef enum logic [1:0] {
        IV_ONE_TWO  = 2'b00,
        IV_HALF_TWO = 2'b01,
        IV_HALF_ONE = 2'b10,
        IV_3Q_3H    = 2'b11
    } ival_e;

    localparam fp_t POS_ONE  = '{sign: 1'b0, exp: EXP_ONE, frac: '0};
    localparam fp_t NEG_ONE  = '{sign: 1'b1, exp: EXP_ONE, frac: '0};
    localparam fp_t QNAN_DEF = '{sign: 1'b1, exp: EXP_ALL1,
                                 frac: {1'b1, {(FRAC_W-1){1'b0}}}};

endpackage

// File: rtl/fp64_lzc.sv
module fp64_lzc #(
    parameter int W  = 52,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    always_comb begin
        cnt_o = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                cnt_o = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/fp64_lshift.sv
module fp64_lshift #(
    parameter int W  = 52,
    parameter int SW = $clog2(W + 1)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = data_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        assign stage[k+1] = amt_i[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    assign data_o = stage[SW];
endmodule

// File: rtl/fp64_mant_core.sv
module fp64_mant_core
    import fp64_mant_pkg::*;
(
    input  fp_t        op_i,
    input  logic [3:0] ctrl_i,
    input  logic       daz_i,
    output mant_out_t  out_o
);
    logic [SHW-1:0]    lead_zeros;
    logic [SHW-1:0]    shift_amt;
    logic [FRAC_W-1:0] shifted_frac;

    fp64_lzc #(.W(FRAC_W), .CW(SHW)) u_lzc (
        .vec_i (op_i.frac),
        .cnt_o (lead_zeros)
    );

    assign shift_amt = lead_zeros + 1'b1;

    fp64_lshift #(.W(FRAC_W), .SW(SHW)) u_shift (
        .data_i (op_i.frac),
        .amt_i  (shift_amt),
        .data_o (shifted_frac)
    );

    logic              exp_min, exp_max, frac_nz;
    logic              is_zero, is_sub, is_inf, is_nan;
    logic              odd_exp, sc_pos, sc_inv;
    ival_e             ival;
    logic [FRAC_W-1:0] norm_frac;
    logic [EXP_W-1:0]  new_exp;
    fp_t               signed_one;

    always_comb begin
        exp_min = (op_i.exp == '0);
        exp_max = (op_i.exp == EXP_ALL1);
        frac_nz = |op_i.frac;
        is_zero = exp_min && (!frac_nz || daz_i);
        is_sub  = exp_min && frac_nz && !daz_i;
        is_inf  = exp_max && !frac_nz;
        is_nan  = exp_max && frac_nz;

        sc_pos     = ctrl_i[2];
        sc_inv     = ctrl_i[3];
        ival       = ival_e'(ctrl_i[1:0]);
        signed_one = sc_pos ? POS_ONE : NEG_ONE;

        // unbiased parity: bias is odd, so the biased lsb is inverted;
        // a subnormal's unbiased exponent is minus the shift count
        norm_frac = is_sub ? shifted_frac : op_i.frac;
        odd_exp   = is_sub ? shift_amt[0] : ~op_i.exp[0];

        unique case (ival)
            IV_ONE_TWO:  new_exp = EXP_ONE;
            IV_HALF_TWO: new_exp = odd_exp ? EXP_HALF : EXP_ONE;
            IV_HALF_ONE: new_exp = EXP_HALF;
            IV_3Q_3H:    new_exp = norm_frac[FRAC_W-1] ? EXP_HALF : EXP_ONE;
            default:     new_exp = EXP_ONE;
        endcase

        out_o.res.sign = sc_pos ? 1'b0 : op_i.sign;
        out_o.res.exp  = new_exp;
        out_o.res.frac = norm_frac;
        out_o.inv      = 1'b0;
        out_o.den      = is_sub;

        if (is_nan) begin
            out_o.res = op_i;
            out_o.res.frac[FRAC_W-1] = 1'b1;
            out_o.inv = ~op_i.frac[FRAC_W-1];
            out_o.den = 1'b0;
        end else if (!op_i.sign && (is_zero || is_inf)) begin
            out_o.res = POS_ONE;
            out_o.den = 1'b0;
        end else if (op_i.sign && is_zero) begin
            out_o.res = signed_one;
            out_o.den = 1'b0;
        end else if (op_i.sign && (is_inf || sc_inv)) begin
            out_o.res = sc_inv ? QNAN_DEF : signed_one;
            out_o.inv = sc_inv;
            out_o.den = 1'b0;
        end
    end
endmodule

// File: rtl/fp64_mant_norm.sv
module fp64_mant_norm
    import fp64_mant_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] op_i,
    input  logic [3:0]  ctrl_i,
    input  logic        daz_i,
    output logic [63:0] res_o,
    output logic        invalid_o,
    output logic        denorm_o
);
    mant_out_t core_out;
    mant_out_t st_d, st_q;

    fp64_mant_core u_core (
        .op_i   (fp_t'(op_i)),
        .ctrl_i (ctrl_i),
        .daz_i  (daz_i),
        .out_o  (core_out)
    );

    always_comb begin
        st_d = core_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o     = st_q.res;
    assign invalid_o = st_q.inv;
    assign denorm_o  = st_q.den;
endmodule

// File: rtl/fp64_mant_norm_chk.sv
module fp64_mant_norm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] op_i,
    input logic [3:0]  ctrl_i,
    input logic        daz_i,
    input logic [63:0] res_o,
    input logic        invalid_o,
    input logic        denorm_o
);
    logic past_ok;
    logic in_nan, in_normal, in_zero;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign in_nan    = (op_i[62:52] == 11'h7FF) && (op_i[51:0] != '0);
    assign in_normal = (op_i[62:52] != 11'h000) && (op_i[62:52] != 11'h7FF);
    assign in_zero   = (op_i[62:52] == 11'h000) && ((op_i[51:0] == '0) || daz_i);

    AST_INVALID_IS_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (res_o[62:51] == 12'hFFF)); // R8

    AST_DENORM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        denorm_o |-> (!invalid_o && res_o[62:53] == 10'h1FF)); // R12

    AST_NAN_QUIETED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_nan)) |->
        (res_o == {$past(op_i[63]), 11'h7FF, 1'b1, $past(op_i[50:0])}
         && invalid_o == !$past(op_i[51]))); // R6

    AST_NEG_SC1_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i[63] && ctrl_i[3] && !in_zero && !in_nan)) |->
        (invalid_o && res_o == 64'hFFF8_0000_0000_0000)); // R8

    AST_POS_ZERO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!op_i[63] && in_zero)) |->
        (res_o == 64'h3FF0_0000_0000_0000 && !invalid_o && !denorm_o)); // R7

    AST_SC0_CLEARS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctrl_i[2] && !in_nan) && !invalid_o) |-> !res_o[63]); // R5

    AST_HALF_ONE_EXP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctrl_i[1:0] == 2'b10 && in_normal && !op_i[63])) |->
        (res_o[62:52] == 11'h3FE && res_o[51:0] == $past(op_i[51:0]))); // R2
endmodule

bind fp64_mant_norm fp64_mant_norm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .ctrl_i    (ctrl_i),
    .daz_i     (daz_i),
    .res_o     (res_o),
    .invalid_o (invalid_o),
    .denorm_o  (denorm_o)
);

// File: tb/fp64_mant_norm_test.sv
`timescale 1ns/1ps
module fp64_mant_norm_test;

    localparam logic [63:0] P1 = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] N1 = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] QD = 64'hFFF8_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op = '0;
    logic [3:0]  ctrl = '0;
    logic        daz = 1'b0;
    logic [63:0] res;
    logic        inv, den;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fp64_mant_norm uut (
        .clk (clk), .rst_n (rst_n), .op_i (op), .ctrl_i (ctrl), .daz_i (daz),
        .res_o (res), .invalid_o (inv), .denorm_o (den)
    );

    // behavioural model: {invalid, denorm, result}
    function automatic logic [65:0] ref_model(input logic [63:0] x,
                                              input logic [3:0] c, input logic d);
        logic        s = x[63];
        logic [10:0] e = x[62:52];
        logic [51:0] f = x[51:0];
        logic [63:0] sone = c[2] ? P1 : N1;
        logic        zr = (e == 0) && (f == 0 || d);
        logic        sb = (e == 0) && (f != 0) && !d;
        logic        nf = (e == 11'h7FF) && (f == 0);
        logic        nn = (e == 11'h7FF) && (f != 0);
        int          ue;
        logic        jb, odd;
        logic [10:0] oe;
        if (nn) return {~f[51], 1'b0, s, 11'h7FF, 1'b1, f[50:0]};
        if (!s && (zr || nf)) return {2'b00, P1};
        if (s && zr) return {2'b00, sone};
        if (s && nf) return c[3] ? {2'b10, QD} : {2'b00, sone};
        if (s && c[3]) return {2'b10, QD};
        if (sb) begin
            ue = 0;
            jb = 1'b0;
            while (!jb) begin
                jb = f[51];
                f  = f << 1;
                ue = ue - 1;
            end
        end else begin
            ue = int'(e) - 1023;
        end
        odd = (ue % 2) != 0;
        case (c[1:0])
            2'b00:   oe = 11'd1023;
            2'b01:   oe = odd ? 11'd1022 : 11'd1023;
            2'b10:   oe = 11'd1022;
            default: oe = f[51] ? 11'd1022 : 11'd1023;
        endcase
        return {1'b0, sb, c[2] ? 1'b0 : s, oe, f};
    endfunction

    function automatic string tag_of(input logic [63:0] x, input logic [3:0] c,
                                     input logic d);
        if (x[62:52] == 11'h7FF && x[51:0] != 0) return "R6";
        if (x[62:52] == 11'h7FF) return x[63] ? (c[3] ? "R8" : "R9") : "R7";
        if (x[62:52] == 0 && (x[51:0] == 0 || d)) return d ? "R10" : "R7";
        if (x[63] && c[3]) return "R8";
        if (x[62:52] == 0) return "R11";
        case (c[1:0])
            2'b01:   return "R3";
            2'b11:   return "R4";
            default: return c[2] ? "R5" : "R2";
        endcase
    endfunction

    task automatic compare(input logic [63:0] er, input logic ei, input logic ed,
                           input string tag);
        nchk++;
        if (res !== er || inv !== ei || den !== ed) begin
            nfail++;
            $display("FAIL %s: op=%h ctrl=%b daz=%b actual res=%h inv=%b den=%b expected res=%h inv=%b den=%b",
                     tag, op, ctrl, daz, res, inv, den, er, ei, ed);
        end
    endtask

    task automatic run_case(input logic [63:0] x, input logic [3:0] c, input logic d,
                            input logic [63:0] er, input logic ei, input logic ed,
                            input string tag);
        @(negedge clk);
        op = x; ctrl = c; daz = d;
        @(negedge clk);
        compare(er, ei, ed, tag);
    endtask

    task automatic ref_case(input logic [63:0] x, input logic [3:0] c, input logic d,
                            input string tag);
        logic [65:0] m = ref_model(x, c, d);
        run_case(x, c, d, m[63:0], m[65], m[64], tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E_ED01));
        op = 64'h4018_0000_0000_0000;
        repeat (3) @(negedge clk);
        compare(64'h0, 1'b0, 1'b0, "R1 reset");
        rst_n = 1'b1;

        // R2: 6.0 and 3.0 under fixed intervals
        run_case(64'h4018_0000_0000_0000, 4'b0000, 0, 64'h3FF8_0000_0000_0000, 0, 0, "R2");
        run_case(64'h4018_0000_0000_0000, 4'b0010, 0, 64'h3FE8_0000_0000_0000, 0, 0, "R2");
        // R1: new operand held off until the next rising edge
        @(negedge clk);
        op = 64'h4008_0000_0000_0000; ctrl = 4'b0001;
        #1 compare(64'h3FE8_0000_0000_0000, 0, 0, "R1 hold");
        @(negedge clk);
        compare(64'h3FE8_0000_0000_0000, 0, 0, "R3 odd");
        // R3: even exponent
        run_case(64'h4018_0000_0000_0000, 4'b0001, 0, 64'h3FF8_0000_0000_0000, 0, 0, "R3 even");
        // R4: top fraction bit set / clear
        run_case(64'h4018_0000_0000_0000, 4'b0011, 0, 64'h3FE8_0000_0000_0000, 0, 0, "R4");
        run_case(64'h4004_0000_0000_0000, 4'b0011, 0, 64'h3FF4_0000_0000_0000, 0, 0, "R4");
        // R5: sign control
        run_case(64'hC018_0000_0000_0000, 4'b0000, 0, 64'hBFF8_0000_0000_0000, 0, 0, "R5");
        run_case(64'hC018_0000_0000_0000, 4'b0100, 0, 64'h3FF8_0000_0000_0000, 0, 0, "R5");
        // R6: NaNs
        run_case(64'h7FF0_0000_0000_0001, 4'b0010, 0, 64'h7FF8_0000_0000_0001, 1, 0, "R6 snan");
        run_case(64'hFFF8_0000_0000_0123, 4'b1111, 0, 64'hFFF8_0000_0000_0123, 0, 0, "R6 qnan");
        // R7: zeros and +inf
        run_case(64'h0000_0000_0000_0000, 4'b1011, 0, P1, 0, 0, "R7 +0");
        run_case(64'h7FF0_0000_0000_0000, 4'b0010, 0, P1, 0, 0, "R7 +inf");
        run_case(64'h8000_0000_0000_0000, 4'b0000, 0, N1, 0, 0, "R7 -0");
        run_case(64'h8000_0000_0000_0000, 4'b1000, 0, N1, 0, 0, "R7 -0 sc1");
        run_case(64'h8000_0000_0000_0000, 4'b0100, 0, P1, 0, 0, "R7 -0 sc0");
        // R8 and R9: negative inputs
        run_case(64'hC018_0000_0000_0000, 4'b1000, 0, QD, 1, 0, "R8");
        run_case(64'hFFF0_0000_0000_0000, 4'b1000, 0, QD, 1, 0, "R8 -inf");
        run_case(64'hFFF0_0000_0000_0000, 4'b0000, 0, N1, 0, 0, "R9");
        run_case(64'hFFF0_0000_0000_0000, 4'b0110, 0, P1, 0, 0, "R9");
        // R10: denormals-are-zero
        run_case(64'h0006_0000_0000_0000, 4'b0011, 1, P1, 0, 0, "R10");
        run_case(64'h8006_0000_0000_0000, 4'b1000, 1, N1, 0, 0, "R10");
        // R11: subnormal normalization
        run_case(64'h0000_0000_0000_0001, 4'b0001, 0, P1, 0, 1, "R11 lsb");
        run_case(64'h0008_0000_0000_0000, 4'b0001, 0, 64'h3FE0_0000_0000_0000, 0, 1, "R11 msb");
        run_case(64'h0006_0000_0000_0000, 4'b0011, 0, 64'h3FE8_0000_0000_0000, 0, 1, "R11");
        run_case(64'h0006_0000_0000_0000, 4'b0001, 0, 64'h3FF8_0000_0000_0000, 0, 1, "R11");
        // R12: collision of normalization with the invalid rule
        run_case(64'h8006_0000_0000_0000, 4'b1000, 0, QD, 1, 0, "R12");
        run_case(64'h8006_0000_0000_0000, 4'b0000, 0, 64'hBFF8_0000_0000_0000, 0, 1, "R12");

        for (int n = 0; n < 4000; n++) begin
            logic [63:0] x;
            logic [51:0] fr;
            logic [3:0]  c;
            logic        d;
            int          k;
            k  = $urandom % 8;
            fr = {$urandom, $urandom};
            c  = 4'($urandom);
            d  = ($urandom % 4) == 0;
            x[63] = 1'($urandom);
            if (k < 2) begin
                x[62:52] = 11'h000;
                x[51:0]  = fr >> ($urandom % 53);
            end else if (k == 2) begin
                x[62:52] = 11'h7FF;
                x[51:0]  = ($urandom % 2) ? fr : 52'h0;
            end else begin
                x[62:52] = 11'($urandom % 2046 + 1);
                x[51:0]  = fr;
            end
            ref_case(x, c, d, tag_of(x, c, d));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule